// File: doc/BRIEF.md
# Device-side command mailbox register file

This block is the device end of a host-to-device command mailbox. A host engine sees a small register window through a plain word-wide write/read port. In it are a capability word, a control word whose bit 0 is the doorbell, an opcode word, a payload-length word, a return-code word, a device-status word, and a payload RAM window. The host fills in the opcode, the length and the payload, then rings the doorbell. The device runs the command and writes back a return code and an output length. Only after that does it clear the doorbell.

The command handler is built in and kept small for testing. One opcode is an echo: the handler passes over each input payload word, writes the same data back, and reports success. The output length it reports is the input length, limited to the RAM capacity. Any other opcode returns an "unsupported" code with length zero. Ownership alternates. The host owns every writable register while the doorbell is clear. The device owns them while it is set. Once the doorbell drops, nothing changes until the host rings again.

Top module: `mbox_device_regfile`

## Requirements
- R1: After reset the doorbell reads 0 and the ready bit (device-status bit 0) reads 0. The ready bit reads 1 once READY_DLY cycles have passed after reset release, and stays 1.
- R2: A host write of a word with bit 0 set to the control word (word 1) sets the doorbell. While a command runs, control bit 0 reads 1, and a host write of 0 does not clear it. Only command completion clears it.
- R3: A doorbell ring written while the ready bit is 0 is ignored, and the control word still reads 0.
- R4: While the doorbell is set, host writes to the opcode word (word 2, bits 15:0), the length word (word 3, bits 20:0) and the payload window (address MSB set, low bits select the word) have no effect.
- R5: While the doorbell is clear, the device changes none of the length, return-code or payload contents. The host can then write the opcode, length and payload, and read back what it wrote.
- R6: The capability word (word 0) reports in bits 4:0 the payload capacity as a power-of-two exponent PAY_EXP. Elaboration rejects any exponent below 8 (256 bytes) or above 20 (1 MiB).
- R7: The device-status word (word 5) carries ready in bit 0, the fatal-error input in bit 1 and the firmware-halted input in bit 2. All other bits read 0.
- R8: The echo opcode (ECHO_OP) completes with return code 0 in the return-code word (word 4, bits 15:0). The payload is left holding the input data. The length word then holds the input length, limited to the capacity.
- R9: Any other opcode completes with return code 0x0015 and length 0, and leaves the payload untouched.
- R10: A length that the device reports never exceeds the payload capacity in bytes. An input length larger than the capacity is reported back as exactly the capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe for one cycle |
| host_addr | input | PAY_EXP-1 | Word address; MSB set selects the payload window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| fatal_err_i | input | 1 | Device fatal-error condition, shown in device status |
| fw_halt_i | input | 1 | Firmware-halted condition, shown in device status |

## Verification
Some behaviour is checked by the assertions on every cycle. The doorbell only falls on a completion. It never rises before ready. The opcode and length hold while a command is in flight. The device writes neither the payload nor the result registers while the doorbell is clear. A completed length never exceeds capacity. Other behaviour only the bench scenarios can show, because it depends on data values: that an echo leaves the written payload intact, that results carry the right return code and length, that capability and status read correctly, and that host writes landing mid-command leave no trace once the command finishes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned LEN_W  = 21;
  localparam int unsigned RC_W   = 16;

  // register word selects (low address bits, payload window excluded)
  localparam logic [2:0] SEL_CAP   = 3'd0;
  localparam logic [2:0] SEL_CTRL  = 3'd1;
  localparam logic [2:0] SEL_OPC   = 3'd2;
  localparam logic [2:0] SEL_LEN   = 3'd3;
  localparam logic [2:0] SEL_RC    = 3'd4;
  localparam logic [2:0] SEL_DSTAT = 3'd5;

  localparam logic [RC_W-1:0] RC_SUCCESS     = 16'h0000;
  localparam logic [RC_W-1:0] RC_UNSUPPORTED = 16'h0015;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_COPY = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/mbox_ready_timer.sv
module mbox_ready_timer #(
  parameter int unsigned READY_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(READY_DLY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !rdy_q;
    cnt_d  = cnt_q + CNT_W'(1);
    rdy_d  = rdy_q | (cnt_q == CNT_W'(READY_DLY - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/mbox_payload_ram.sv
module mbox_payload_ram #(
  parameter int unsigned IDX_W = 6
) (
  input  logic                       clk,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           widx_i,
  input  logic [mbox_pkg::WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]           ridx_a_i,
  output logic [mbox_pkg::WORD_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]           ridx_b_i,
  output logic [mbox_pkg::WORD_W-1:0] rdata_b_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [mbox_pkg::WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/mbox_echo_engine.sv
module mbox_echo_engine
  import mbox_pkg::*;
#(
  parameter int unsigned    PAY_EXP = 8,
  parameter logic [OP_W-1:0] ECHO_OP = 16'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  output logic [PAY_EXP-3:0] idx_o,
  output logic               wr_en_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic               done_o,
  output logic [RC_W-1:0]    rc_o,
  output logic [LEN_W-1:0]   olen_o
);
  localparam int unsigned    IDX_W = PAY_EXP - 2;
  localparam logic [LEN_W-1:0] CAP_B = LEN_W'(1 << PAY_EXP);

  eng_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [RC_W-1:0]   rc_q, rc_d;
  logic [LEN_W-1:0]  olen_q, olen_d;
  logic [LEN_W-1:0]  len_eff, words;
  logic              res_en;

  always_comb begin
    len_eff = (len_i > CAP_B) ? CAP_B : len_i;
    words   = (len_eff + LEN_W'(3)) >> 2;
    st_d    = st_q;
    idx_d   = idx_q;
    last_d  = last_q;
    rc_d    = rc_q;
    olen_d  = olen_q;
    res_en  = 1'b0;
    wr_en_o = 1'b0;
    unique case (st_q)
      ENG_IDLE: if (go_i) begin
        res_en = 1'b1;
        idx_d  = '0;
        if (opcode_i == ECHO_OP) begin
          rc_d   = RC_SUCCESS;
          olen_d = len_eff;
          last_d = IDX_W'(words - LEN_W'(1));
          st_d   = (words == '0) ? ENG_DONE : ENG_COPY;
        end else begin
          rc_d   = RC_UNSUPPORTED;
          olen_d = '0;
          st_d   = ENG_DONE;
        end
      end
      ENG_COPY: begin
        wr_en_o = 1'b1;
        if (idx_q == last_q) st_d = ENG_DONE;
        else                 idx_d = idx_q + IDX_W'(1);
      end
      ENG_DONE: st_d = ENG_IDLE;
      default:  st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      rc_q   <= '0;
      olen_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (res_en) begin
        last_q <= last_d;
        rc_q   <= rc_d;
        olen_q <= olen_d;
      end
    end
  end

  assign idx_o     = idx_q;
  assign wr_data_o = rd_data_i;
  assign done_o    = (st_q == ENG_DONE);
  assign rc_o      = rc_q;
  assign olen_o    = olen_q;
endmodule

// File: rtl/mbox_device_regfile.sv
module mbox_device_regfile
  import mbox_pkg::*;
#(
  parameter int unsigned     PAY_EXP   = 8,
  parameter int unsigned     READY_DLY = 16,
  parameter logic [OP_W-1:0] ECHO_OP   = 16'h0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [PAY_EXP-2:0]   host_addr,
  input  logic [WORD_W-1:0]    host_wdata,
  output logic [WORD_W-1:0]    host_rdata,
  input  logic                 fatal_err_i,
  input  logic                 fw_halt_i
);
  localparam int unsigned IDX_W  = PAY_EXP - 2;
  localparam int unsigned ADDR_W = IDX_W + 1;

  if (PAY_EXP < 8 || PAY_EXP > 20) begin : g_bad_cap
    $error("payload exponent outside 8..20");
  end

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta_q  <= 1'b1;
      rst_sync_n <= rs_meta_q;
    end
  end

  logic              ready;
  logic              doorbell_q, doorbell_d, ring_q, ring;
  logic [OP_W-1:0]   opcode_q, opcode_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [RC_W-1:0]   rc_q, rc_d;
  logic              opc_en, len_en, rc_en;
  logic              is_pay, reg_hit, host_open;
  logic [2:0]        reg_sel;
  logic              eng_done, eng_we;
  logic [IDX_W-1:0]  eng_idx;
  logic [WORD_W-1:0] eng_wdata, eng_rdata, host_pay_rdata;
  logic [RC_W-1:0]   eng_rc;
  logic [LEN_W-1:0]  eng_olen;
  logic              pay_we;
  logic [IDX_W-1:0]  pay_widx;
  logic [WORD_W-1:0] pay_wdata;

  mbox_ready_timer #(.READY_DLY(READY_DLY)) u_rdy (
    .clk(clk), .rst_n(rst_sync_n), .ready_o(ready)
  );

  // address decode and host ownership
  always_comb begin
    is_pay    = host_addr[ADDR_W-1];
    reg_sel   = host_addr[2:0];
    reg_hit   = !is_pay && (host_addr[ADDR_W-2:3] == '0);
    host_open = !doorbell_q;
    ring      = host_we && reg_hit && (reg_sel == SEL_CTRL) && host_wdata[0]
                && host_open && ready;
  end

  // next-state for the register words
  always_comb begin
    doorbell_d = doorbell_q;
    if (eng_done)  doorbell_d = 1'b0;
    else if (ring) doorbell_d = 1'b1;
    opc_en   = host_open && host_we && reg_hit && (reg_sel == SEL_OPC);
    opcode_d = host_wdata[OP_W-1:0];
    len_en   = eng_done || (host_open && host_we && reg_hit && (reg_sel == SEL_LEN));
    len_d    = eng_done ? eng_olen : host_wdata[LEN_W-1:0];
    rc_en    = eng_done;
    rc_d     = eng_rc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      doorbell_q <= 1'b0;
      ring_q     <= 1'b0;
      opcode_q   <= '0;
      len_q      <= '0;
      rc_q       <= '0;
    end else begin
      doorbell_q <= doorbell_d;
      ring_q     <= ring;
      if (opc_en) opcode_q <= opcode_d;
      if (len_en) len_q    <= len_d;
      if (rc_en)  rc_q     <= rc_d;
    end
  end

  mbox_echo_engine #(.PAY_EXP(PAY_EXP), .ECHO_OP(ECHO_OP)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .go_i(ring_q),
    .opcode_i(opcode_q), .len_i(len_q), .rd_data_i(eng_rdata),
    .idx_o(eng_idx), .wr_en_o(eng_we), .wr_data_o(eng_wdata),
    .done_o(eng_done), .rc_o(eng_rc), .olen_o(eng_olen)
  );

  // payload write port: device while busy, host while idle
  always_comb begin
    pay_we    = eng_we || (host_open && host_we && is_pay);
    pay_widx  = eng_we ? eng_idx   : host_addr[IDX_W-1:0];
    pay_wdata = eng_we ? eng_wdata : host_wdata;
  end

  mbox_payload_ram #(.IDX_W(IDX_W)) u_ram (
    .clk(clk), .we_i(pay_we), .widx_i(pay_widx), .wdata_i(pay_wdata),
    .ridx_a_i(host_addr[IDX_W-1:0]), .rdata_a_o(host_pay_rdata),
    .ridx_b_i(eng_idx), .rdata_b_o(eng_rdata)
  );

  always_comb begin
    host_rdata = '0;
    if (is_pay) host_rdata = host_pay_rdata;
    else if (reg_hit) begin
      unique case (reg_sel)
        SEL_CAP:   host_rdata = WORD_W'(PAY_EXP);
        SEL_CTRL:  host_rdata = WORD_W'(doorbell_q);
        SEL_OPC:   host_rdata = WORD_W'(opcode_q);
        SEL_LEN:   host_rdata = WORD_W'(len_q);
        SEL_RC:    host_rdata = WORD_W'(rc_q);
        SEL_DSTAT: host_rdata = WORD_W'({fw_halt_i, fatal_err_i, ready});
        default:   host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk #(
  parameter logic [20:0] CAP_BYTES = 21'd256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        doorbell,
  input logic        ready,
  input logic        eng_done,
  input logic        eng_we,
  input logic        host_we,
  input logic [15:0] opcode,
  input logic [20:0] len,
  input logic [15:0] rc,
  input logic [20:0] eng_olen
);
  // R2
  db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && !eng_done) |=> doorbell);

  // R3
  no_early_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !doorbell);

  // R4
  opc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> $stable(opcode));

  // R4
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && !eng_done) |=> $stable(len));

  // R5
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doorbell && !host_we) |=> ($stable(len) && $stable(rc)));

  // R5
  idle_no_dev_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !doorbell |-> !eng_we);

  // R10
  olen_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (eng_olen <= CAP_BYTES));
endmodule

bind mbox_device_regfile mbox_regfile_chk #(.CAP_BYTES(21'(1 << PAY_EXP))) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .doorbell(doorbell_q), .ready(ready),
  .eng_done(eng_done), .eng_we(eng_we), .host_we(host_we),
  .opcode(opcode_q), .len(len_q), .rc(rc_q), .eng_olen(eng_olen)
);

// File: tb/tb_mbox_device_regfile.sv
module tb_mbox_device_regfile;
  localparam int unsigned PAY_EXP = 8;
  localparam int unsigned AW      = PAY_EXP - 1;
  localparam logic [15:0] ECHO    = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_we;
  logic [AW-1:0] host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic          fatal_err_i, fw_halt_i;

  always #2 clk = ~clk;

  mbox_device_regfile #(.PAY_EXP(PAY_EXP), .READY_DLY(16), .ECHO_OP(ECHO)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fatal_err_i(fatal_err_i), .fw_halt_i(fw_halt_i)
  );

  typedef struct { string req; logic [31:0] exp; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] act_q[$];
  int          n_vec = 0, n_bad = 0;
  bit          finished = 0;

  function automatic logic [AW-1:0] pay(int i);
    return AW'((1 << (AW - 1)) | i);
  endfunction
  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  // driver: push expected value, then the observed read result
  task automatic expect_rd(logic [AW-1:0] a, logic [31:0] e, string req);
    logic [31:0] v;
    rd(a, v);
    exp_q.push_back('{req, e});
    act_q.push_back(v);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 1000; k++) begin
      rd(AW'(1), v);
      if (v[0] == 1'b0) return;
    end
    exp_q.push_back('{"R2", 32'h0});
    act_q.push_back(32'h1);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [31:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_vec++;
        if (a !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.req, a, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    fatal_err_i = 1'b0; fw_halt_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(AW'(1), 32'h0, "R1");
    expect_rd(AW'(5), 32'h0, "R1");
    // R3 ring while not ready
    wr(AW'(1), 32'h1);
    expect_rd(AW'(1), 32'h0, "R3");
    repeat (30) @(negedge clk);
    expect_rd(AW'(5), 32'h1, "R1");
    // R6 capability
    expect_rd(AW'(0), 32'(PAY_EXP), "R6");
    // R7 device status bits
    fatal_err_i = 1'b1;
    expect_rd(AW'(5), 32'h3, "R7");
    fatal_err_i = 1'b0; fw_halt_i = 1'b1;
    expect_rd(AW'(5), 32'h5, "R7");
    fw_halt_i = 1'b0;
    // fill payload
    for (int i = 0; i < 64; i++) wr(pay(i), pat(i));
    expect_rd(pay(63), pat(63), "R5");
    // echo, 37 bytes -> 10 words, with host writes during busy
    wr(AW'(2), 32'(ECHO));
    wr(AW'(3), 32'd37);
    expect_rd(AW'(3), 32'd37, "R5");
    wr(AW'(1), 32'h1);
    expect_rd(AW'(1), 32'h1, "R2");
    wr(AW'(1), 32'h0);
    wr(AW'(2), 32'hDEAD);
    wr(AW'(3), 32'd5);
    wr(pay(0), 32'hBAD0_BAD0);
    expect_rd(AW'(1), 32'h1, "R2");
    wait_idle();
    expect_rd(AW'(4), 32'h0, "R8");
    expect_rd(AW'(3), 32'd37, "R8");
    expect_rd(AW'(2), 32'(ECHO), "R4");
    expect_rd(pay(0), pat(0), "R4");
    expect_rd(pay(9), pat(9), "R8");
    // R5 nothing moves while idle
    repeat (20) @(negedge clk);
    expect_rd(AW'(3), 32'd37, "R5");
    expect_rd(AW'(4), 32'h0, "R5");
    // R10 oversize length clamps to capacity
    wr(AW'(3), 32'd1000);
    wr(AW'(1), 32'h1);
    wait_idle();
    expect_rd(AW'(3), 32'd256, "R10");
    expect_rd(AW'(4), 32'h0, "R10");
    expect_rd(pay(63), pat(63), "R8");
    // R8 zero length echo
    wr(AW'(3), 32'd0);
    wr(AW'(1), 32'h1);
    wait_idle();
    expect_rd(AW'(3), 32'd0, "R8");
    expect_rd(AW'(4), 32'h0, "R8");
    // R9 unknown opcode
    wr(AW'(2), 32'h0042);
    wr(AW'(3), 32'd12);
    wr(AW'(1), 32'h1);
    wait_idle();
    expect_rd(AW'(4), 32'h0015, "R9");
    expect_rd(AW'(3), 32'd0, "R9");
    expect_rd(pay(1), pat(1), "R9");
    // R5 host owns registers again
    wr(AW'(3), 32'd7);
    expect_rd(AW'(3), 32'd7, "R5");
    wr(pay(2), 32'h1234_5678);
    expect_rd(pay(2), 32'h1234_5678, "R5");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule